// File: doc/BRIEF.md
# Read Prefetch FIFO with Transaction-End Rewind

This block feeds read data to a bus target core from a 32-bit FIFO that back-end logic fills. The oldest stored dword is always shown on the read-data port. Ready is raised whenever at least one entry is stored. Each cycle in which the core strobes advance while ready is high counts as a transfer, and the head entry is taken off at once.

Because the core pulls dwords into its own short read pipeline before they reach the bus, these takes are speculative. On the cycle the core flags as the last transfer, it reports how many dwords are still sitting undelivered in that pipeline. The block then moves its read pointer back by that many entries, so a source whose reads have side effects loses no data. The rewind is clipped so that it never restores more entries than were taken during the current transaction. It is also clipped so that it never reaches slots that new pushes have already reused.

The filling side sees full, empty and a fill count. When the FIFO is empty, the block withholds ready to insert wait states and raises stop to end the access. Both sides share one clock; a parameter is reserved for a later split-clock variant.

Top module: `rd_prefetch_fifo`

## Requirements
- R1: While reset is high and in the first cycle after it: fill count 0, empty 1, full 0, ready 0, stop 1, error flag 0.
- R2: Entries leave in the order they were pushed, and rd_data always equals the oldest stored entry while the FIFO is not empty.
- R3: An entry is taken off only on a clock where core_adv is 1 and ready is 1. Each such clock takes off exactly one entry.
- R4: rd_ready is 0 and rd_stop is 1 exactly when the fill count is 0. Otherwise rd_ready is 1 and rd_stop is 0.
- R5: A push while the FIFO holds DEPTH entries is ignored: the count stays DEPTH and the stored contents and their order are unchanged.
- R6: On a clock with core_last high, the read pointer moves back and the count rises by the pipeline occupancy: code 2'b00 gives 0 entries, 2'b01 gives 1, and 2'b11 gives 2. The restored entries reappear at the head in their original order.
- R7: Occupancy code 2'b10 on a last-transfer clock restores nothing, and occ_err is 1 in the following cycle only. At all other times occ_err is 0.
- R8: A rewind restores at most the number of entries taken since the previous last-transfer clock or reset, counting a take in the same clock. Entries delivered in an earlier transaction never come back.
- R9: A rewind is clipped so that the count after the clock never exceeds DEPTH; restored data is never data a push has overwritten.
- R10: fill_count equals the number of stored entries, fill_full is 1 exactly at DEPTH, and fill_empty is 1 exactly at 0.
- R11: An accepted push and a take in the same clock leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Back end offers a dword |
| push_data | input | 32 | Dword to store |
| fill_full | output | 1 | DEPTH entries stored |
| fill_empty | output | 1 | No entry stored |
| fill_count | output | $clog2(DEPTH)+1 | Entries stored |
| core_adv | input | 1 | Core accepts a dword this clock |
| core_last | input | 1 | Last transfer of the transaction |
| core_pipe | input | 2 | Read-pipeline occupancy code |
| rd_data | output | 32 | Head dword |
| rd_ready | output | 1 | Data available (wait state when low) |
| rd_stop | output | 1 | Request to end the access |
| occ_err | output | 1 | Illegal occupancy code seen on the last clock |

## Verification
The bench aims at rewinds that ask for more than the transaction took, for example a 2'b11 code after a single take or a second last-transfer clock with no takes in between. A design without the clip would bring back dwords that were already delivered, and the bench would see a head value repeated. It also rewinds when only zero or one slot is free after a refill. A design without the room clip would push the count past DEPTH or restore data that a push had overwritten. Further cases are pushes into a full FIFO, where a faulty design would overwrite the head or wrap its count; the illegal 2'b10 code, which must neither move the pointer nor go unflagged; and advance strobes while empty, which must not move the pointer.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        OCC_NONE = 2'b00,
        OCC_ONE  = 2'b01,
        OCC_BAD  = 2'b10,
        OCC_TWO  = 2'b11
    } occ_code_t;

    typedef struct packed {
        logic       push_ok;
        logic       pop;
        logic [1:0] hist;
        logic [1:0] rew;
    } step_t;

    // dwords held in the core's pipeline for a given code
    function automatic logic [1:0] occ_depth(input occ_code_t c);
        case (c)
            OCC_ONE: return 2'd1;
            OCC_TWO: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] min2(input logic [1:0] a, input logic [1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pf_store.sv
module pf_store #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          core_adv,
    input  logic          core_last,
    input  logic [1:0]    core_pipe,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ready,
    output logic          stop,
    output logic          occ_err
);
    logic [AW-1:0] rd_ptr;
    logic [1:0]    hist_q;
    step_t         st;
    logic [CW-1:0] base, room;
    logic [1:0]    want, room2;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign ready = !empty;
    assign stop  = empty;

    always_comb begin
        st.push_ok = push_req && !full;
        st.pop     = core_adv && !empty;
        st.hist    = (st.pop && hist_q != 2'd2) ? hist_q + 2'd1 : hist_q;
        base       = count + CW'(st.push_ok) - CW'(st.pop);
        room       = CW'(DEPTH) - base;
        room2      = (room >= CW'(2)) ? 2'd2 : room[1:0];
        want       = core_last ? occ_depth(occ_code_t'(core_pipe)) : 2'd0;
        st.rew     = min2(min2(want, st.hist), room2);
    end

    assign we    = st.push_ok;
    assign waddr = rd_ptr + count[AW-1:0];
    assign raddr = rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            count   <= '0;
            hist_q  <= '0;
            occ_err <= 1'b0;
        end else begin
            rd_ptr  <= rd_ptr + AW'(st.pop) - AW'(st.rew);
            count   <= base + CW'(st.rew);
            hist_q  <= core_last ? 2'd0 : st.hist;
            occ_err <= core_last && (core_pipe == OCC_BAD);
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !core_adv) |=> full);

    // R3
    idle_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_last && !core_adv) |=> $stable(raddr));

    // R3
    take_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_last && core_adv && !empty) |=> (raddr == $past(raddr) + AW'(1)));

    // R7
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (core_last && core_pipe == 2'b10) |=> occ_err);

    // R8
    rewind_max_chk: assert property (@(posedge clk) disable iff (rst)
        core_last |=> (count <= $past(count) + CW'(3)));

    // R11
    step_max_chk: assert property (@(posedge clk) disable iff (rst)
        !core_last |=> (count <= $past(count) + CW'(1)));
endmodule

// File: rtl/rd_prefetch_fifo.sv
module rd_prefetch_fifo
    import pf_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int ASYNC_CLK = 0,
    localparam int W        = 32,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [W-1:0]  push_data,
    output logic          fill_full,
    output logic          fill_empty,
    output logic [CW-1:0] fill_count,
    input  logic          core_adv,
    input  logic          core_last,
    input  logic [1:0]    core_pipe,
    output logic [W-1:0]  rd_data,
    output logic          rd_ready,
    output logic          rd_stop,
    output logic          occ_err
);
    logic          we;
    logic [AW-1:0] waddr, raddr;

    generate
        if (ASYNC_CLK != 0) begin : g_split_clock_reserved
            $error("split-clock variant not available yet");
        end
        if (DEPTH != 64 && DEPTH != 128) begin : g_bad_depth
            $error("DEPTH must be 64 or 128");
        end
    endgenerate

    pf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_valid),
        .core_adv (core_adv),
        .core_last(core_last),
        .core_pipe(core_pipe),
        .we       (we),
        .waddr    (waddr),
        .raddr    (raddr),
        .count    (fill_count),
        .full     (fill_full),
        .empty    (fill_empty),
        .ready    (rd_ready),
        .stop     (rd_stop),
        .occ_err  (occ_err)
    );

    pf_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(push_data),
        .raddr(raddr),
        .rdata(rd_data)
    );
endmodule

// File: tb/sim_rd_prefetch_fifo.sv
`timescale 1ns/1ps
module sim_rd_prefetch_fifo;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_valid = 1'b0;
    logic [31:0]   push_data = '0;
    logic          fill_full, fill_empty;
    logic [CW-1:0] fill_count;
    logic          core_adv = 1'b0, core_last = 1'b0;
    logic [1:0]    core_pipe = 2'b00;
    logic [31:0]   rd_data;
    logic          rd_ready, rd_stop, occ_err;

    always #2.5 clk = ~clk;

    rd_prefetch_fifo #(.DEPTH(DEPTH)) u0 (.*);

    logic [31:0] q[$];
    logic [31:0] hist[$];
    bit          exp_err;
    int          checks = 0, errors = 0;
    bit          done = 0;
    logic [31:0] seq = 32'hA000_0000;

    task automatic chk(input bit ok, input string req, input string what,
                       input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s [%s]: actual %0h expected %0h", req, what, tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int n = q.size();
        chk(fill_count == CW'(n), "R10", "fill_count", tag, fill_count, n);
        chk(fill_full == (n == DEPTH), "R10", "fill_full", tag, fill_full, n == DEPTH);
        chk(fill_empty == (n == 0), "R10", "fill_empty", tag, fill_empty, n == 0);
        chk(rd_ready == (n != 0), "R4", "rd_ready", tag, rd_ready, n != 0);
        chk(rd_stop == (n == 0), "R4", "rd_stop", tag, rd_stop, n == 0);
        chk(occ_err == exp_err, "R7", "occ_err", tag, occ_err, exp_err);
        if (n != 0) chk(rd_data == q[0], "R2", "rd_data", tag, rd_data, q[0]);
    endtask

    // drive one clock of stimulus, advance the reference model, compare after the edge
    task automatic cyc(input bit p, input bit a, input bit l, input logic [1:0] c,
                       input string tag);
        bit acc;
        int amt;
        push_valid = p; push_data = seq; core_adv = a; core_last = l; core_pipe = c;
        acc = p && (q.size() < DEPTH);
        if (a && q.size() > 0) begin
            hist.push_back(q.pop_front());
            if (hist.size() > 2) void'(hist.pop_front());
        end
        if (acc) q.push_back(seq);
        if (p) seq++;
        if (l) begin
            amt = (c == 2'b01) ? 1 : (c == 2'b11) ? 2 : 0;
            if (amt > hist.size()) amt = hist.size();
            if (amt > DEPTH - q.size()) amt = DEPTH - q.size();
            repeat (amt) q.push_front(hist.pop_back());
            hist.delete();
        end
        exp_err = l && (c == 2'b10);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 2'b00, tag);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        exp_err = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        compare("R1 after reset");

        // R2 R3: fill, take in order, advance low holds the head
        repeat (5) cyc(1, 0, 0, 2'b00, "R2 fill");
        repeat (3) idle("R3 no advance");
        repeat (3) cyc(0, 1, 0, 2'b00, "R3 take");

        // R6: code 01 restores one
        cyc(0, 1, 1, 2'b01, "R6 rewind one");
        // R6: code 11 restores two
        repeat (2) cyc(0, 1, 0, 2'b00, "R6 take");
        cyc(0, 0, 1, 2'b11, "R6 rewind two");
        // R6: code 00 restores none
        cyc(0, 1, 0, 2'b00, "R6 take");
        cyc(0, 1, 1, 2'b00, "R6 rewind zero");
        // R7: illegal code
        cyc(0, 1, 0, 2'b00, "R7 take");
        cyc(0, 0, 1, 2'b10, "R7 bad code");
        idle("R7 flag clears");

        // R8: one take, asks for two
        repeat (4) cyc(1, 0, 0, 2'b00, "R8 refill");
        cyc(0, 1, 0, 2'b00, "R8 take one");
        cyc(0, 0, 1, 2'b11, "R8 clip to one");
        cyc(0, 0, 1, 2'b11, "R8 no takes");

        // R4: drain to empty, advance while empty
        while (q.size() > 0) cyc(0, 1, 0, 2'b00, "R4 drain");
        repeat (3) cyc(0, 1, 0, 2'b00, "R4 advance while empty");
        cyc(0, 1, 1, 2'b11, "R8 last while empty");

        // R5: fill to full, extra pushes ignored
        while (q.size() < DEPTH) cyc(1, 0, 0, 2'b00, "R5 fill");
        repeat (4) cyc(1, 0, 0, 2'b00, "R5 push while full");
        // R11 and push while full with a take
        cyc(1, 1, 0, 2'b00, "R5 full push with take");
        repeat (3) cyc(1, 1, 0, 2'b00, "R11 push and take");
        cyc(0, 0, 1, 2'b11, "R9 no room");
        repeat (2) cyc(0, 1, 0, 2'b00, "R9 take");
        cyc(1, 0, 0, 2'b00, "R9 refill");
        cyc(0, 0, 1, 2'b11, "R9 room for one");
        while (q.size() > 0) cyc(0, 1, 0, 2'b00, "R2 drain order");

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            cyc(bit'($urandom % 2), ($urandom % 4) != 0, ($urandom % 8) == 0,
                2'($urandom % 4), "R6 R8 R9 mixed");
        end
        while (q.size() > 0) cyc(0, 1, 0, 2'b00, "R2 final drain");

        done = 1;
        summary();
        $finish;
    end
endmodule